// File: doc/BRIEF.md
# Register-Programmed Clock Rate Divider

The block divides a single reference clock by a ratio that software programs through a small register bus. The ratio is never written directly. A bit field inside a control word holds a code, and a decode stage turns that code into a divide ratio. The decode stage is picked at elaboration time from four encodings:

- **Offset-by-one:** the ratio is the code plus one.
- **Direct:** the ratio equals the code, and zero is forbidden.
- **Power-of-two:** the ratio is two raised to the code.
- **Lookup table:** the code indexes a table, and a zero entry marks a forbidden code.

The output is a clock-enable pulse, one reference cycle wide, once per divided period. Beside it is a registered phase signal with a duty cycle close to half. The output is never gated, and there is exactly one source clock. A code that decodes to a forbidden or out-of-range ratio is refused. The block keeps the ratio it already had and raises a sticky error flag that software can clear.

A newly accepted ratio is applied only when the running output period completes. As a result, no shortened or stretched period is ever produced during a change. A status word reports the ratio currently in force.

Top module: `clkdiv_prog`

## Requirements
- R1: With MODE = DEC_OFFSET the divide ratio is code + 1, so code 0 divides by 1.
- R2: With MODE = DEC_DIRECT the divide ratio equals the code, and code 0 is refused.
- R3: With MODE = DEC_POW2 the divide ratio is 2 to the power of the code. A code of RATIO_W or more is refused.
- R4: With MODE = DEC_TABLE the ratio is entry `code` of DIV_TABLE, held at bits [code*RATIO_W +: RATIO_W]. A zero entry makes the code refused.
- R5: In the three non-table modes, a decoded ratio below MIN_RATIO or above MAX_RATIO is refused.
- R6: The code lives in bits [FIELD_SHIFT +: FIELD_W] of the control word at address 0. All other written bits are ignored, and they read back as zero.
- R7: A refused control write leaves both the stored code and the applied ratio unchanged. It sets the sticky error flag, which appears on `cfg_err` and in status bit DATA_W-1. Writing address 1 with bit DATA_W-1 set clears the flag.
- R8: A new ratio takes effect only at the end of the output period in progress. Every period therefore lasts exactly the old ratio or the new one.
- R9: `clk_en` is high for one cycle in every N. For N = 1 both `clk_en` and `div_phase` stay high continuously.
- R10: For N >= 2, `div_phase` is high for floor(N/2) cycles, starting with the `clk_en` cycle, and low for the rest of the period.
- R11: Reading address 1 returns the applied ratio in bits [RATIO_W-1:0]. `bus_rdata` is registered and reflects the address presented one cycle earlier.
- R12: After reset the stored code is RST_CODE and the error flag is clear. From the second cycle on, the applied ratio is the decode of RST_CODE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, the only clock source |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word address: 0 control, 1 status |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the previous cycle's address |
| clk_en | output | 1 | One-cycle enable at the start of every divided period |
| div_phase | output | 1 | Divided waveform, high for the first half of the period |
| cfg_err | output | 1 | Sticky flag for a refused divider code |

## Verification
The assertions rest on several assumptions about the inputs and parameters:

- RST_CODE decodes to a legal ratio.
- MIN_RATIO is at least one, and MAX_RATIO fits in RATIO_W bits.
- Bus writes arrive as single-cycle strobes with a stable address and data.

These assumptions guarantee that the pending ratio handed to the period counter is never zero. They also guarantee that the stored code always decodes as legal. The stimulus stays within these limits in several ways. Every instance gets a reset code chosen to be legal for its encoding. Each write is issued as a separate one-cycle strobe. Read-back is done only after the strobe has dropped.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  // Encoding used to turn the register code into a divide ratio
  typedef enum logic [1:0] {
    DEC_OFFSET = 2'd0,  // ratio = code + 1
    DEC_DIRECT = 2'd1,  // ratio = code
    DEC_POW2   = 2'd2,  // ratio = 2**code
    DEC_TABLE  = 2'd3   // ratio = table[code], zero entry forbidden
  } dec_mode_e;

  localparam int unsigned REG_CTRL = 0;
  localparam int unsigned REG_STAT = 1;
endpackage

// File: rtl/clkdiv_decode.sv
module clkdiv_decode #(
  parameter clkdiv_pkg::dec_mode_e MODE = clkdiv_pkg::DEC_OFFSET,
  parameter int unsigned FIELD_W   = 4,
  parameter int unsigned RATIO_W   = 8,
  parameter int unsigned MIN_RATIO = 1,
  parameter int unsigned MAX_RATIO = 16,
  parameter logic [(2**FIELD_W)*RATIO_W-1:0] DIV_TABLE = '0
) (
  input  logic [FIELD_W-1:0] code,
  output logic [RATIO_W-1:0] ratio,
  output logic               valid
);
  // Intermediate width large enough for code + 1 without wrapping
  localparam int unsigned WW = ((FIELD_W > RATIO_W) ? FIELD_W : RATIO_W) + 1;

  generate
    if (MODE == clkdiv_pkg::DEC_TABLE) begin : g_tbl
      logic [RATIO_W-1:0] entry;
      always_comb entry = DIV_TABLE[code*RATIO_W +: RATIO_W];
      assign ratio = entry;
      assign valid = (entry != '0);
    end else begin : g_arith
      logic [WW-1:0] wide;
      if (MODE == clkdiv_pkg::DEC_OFFSET) begin : g_off
        assign wide = WW'(code) + WW'(1);
      end else if (MODE == clkdiv_pkg::DEC_DIRECT) begin : g_dir
        assign wide = WW'(code);
      end else begin : g_p2
        // codes that cannot be represented decode to zero, i.e. refused
        assign wide = (WW'(code) < WW'(RATIO_W)) ? (WW'(1) << code) : '0;
      end
      assign ratio = wide[RATIO_W-1:0];
      assign valid = (wide != '0) && (wide >= WW'(MIN_RATIO)) &&
                     (wide <= WW'(MAX_RATIO));
    end
  endgenerate
endmodule

// File: rtl/clkdiv_regs.sv
module clkdiv_regs #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned FIELD_W     = 4,
  parameter int unsigned FIELD_SHIFT = 8,
  parameter int unsigned RATIO_W     = 8,
  parameter int unsigned RST_CODE    = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [FIELD_W-1:0] wr_field,
  input  logic               wr_valid,
  input  logic [RATIO_W-1:0] cur_ratio,
  output logic [FIELD_W-1:0] code_q,
  output logic               err_q,
  output logic [DATA_W-1:0]  bus_rdata
);
  logic sel_ctrl, sel_stat;
  logic [DATA_W-1:0] stat_word, ctrl_word;

  assign sel_ctrl = (bus_addr == ADDR_W'(clkdiv_pkg::REG_CTRL));
  assign sel_stat = (bus_addr == ADDR_W'(clkdiv_pkg::REG_STAT));
  assign wr_field = bus_wdata[FIELD_SHIFT +: FIELD_W];

  // Stored code and sticky error flag
  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= FIELD_W'(RST_CODE);
      err_q  <= 1'b0;
    end else if (bus_wr) begin
      if (sel_ctrl) begin
        if (wr_valid) code_q <= wr_field;
        else          err_q  <= 1'b1;
      end else if (sel_stat && bus_wdata[DATA_W-1]) begin
        err_q <= 1'b0;
      end
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[FIELD_SHIFT +: FIELD_W] = code_q;
    stat_word = '0;
    stat_word[RATIO_W-1:0] = cur_ratio;
    stat_word[DATA_W-1] = err_q;
  end

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst)           bus_rdata <= '0;
    else if (sel_ctrl) bus_rdata <= ctrl_word;
    else if (sel_stat) bus_rdata <= stat_word;
    else               bus_rdata <= '0;
  end

  assert_bad_code_kept_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel_ctrl && !wr_valid) |=> ($stable(code_q) && err_q));

  assert_err_cleared_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel_stat && bus_wdata[DATA_W-1]) |=> !err_q);
endmodule

// File: rtl/clkdiv_gen.sv
module clkdiv_gen #(
  parameter int unsigned RATIO_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] pend_ratio,
  output logic [RATIO_W-1:0] cur_ratio,
  output logic               clk_en,
  output logic               div_phase
);
  logic [RATIO_W-1:0] cnt_q, cur_q, cnt_n, cur_n, hi_n;
  logic               wrap;

  // Period counter; the pending ratio is adopted only at a wrap
  always_comb begin
    wrap = (cnt_q == cur_q - RATIO_W'(1));
    if (wrap) begin
      cnt_n = '0;
      cur_n = pend_ratio;
    end else begin
      cnt_n = cnt_q + RATIO_W'(1);
      cur_n = cur_q;
    end
    // high phase: floor(N/2) cycles, whole period for N = 1
    hi_n = (cur_n == RATIO_W'(1)) ? RATIO_W'(1) : (cur_n >> 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      cur_q     <= RATIO_W'(1);
      clk_en    <= 1'b1;
      div_phase <= 1'b1;
    end else begin
      cnt_q     <= cnt_n;
      cur_q     <= cur_n;
      clk_en    <= (cnt_n == '0);
      div_phase <= (cnt_n < hi_n);
    end
  end

  assign cur_ratio = cur_q;

  assert_ratio_changes_at_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(cur_q) |-> (cnt_q == '0));

  assert_count_in_period_R8: assert property (@(posedge clk) disable iff (rst)
    cnt_q < cur_q);

  assert_pending_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
    pend_ratio != '0);

  assert_single_enable_R9: assert property (@(posedge clk) disable iff (rst)
    (clk_en && (cur_q != RATIO_W'(1))) |=> !clk_en);

  assert_phase_starts_high_R10: assert property (@(posedge clk) disable iff (rst)
    clk_en |-> div_phase);
endmodule

// File: rtl/clkdiv_prog.sv
module clkdiv_prog #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned FIELD_W     = 4,
  parameter int unsigned FIELD_SHIFT = 8,
  parameter int unsigned RATIO_W     = 8,
  parameter int unsigned MIN_RATIO   = 1,
  parameter int unsigned MAX_RATIO   = 16,
  parameter clkdiv_pkg::dec_mode_e MODE = clkdiv_pkg::DEC_OFFSET,
  parameter logic [(2**FIELD_W)*RATIO_W-1:0] DIV_TABLE = '0,
  parameter int unsigned RST_CODE    = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              clk_en,
  output logic              div_phase,
  output logic              cfg_err
);
  logic [FIELD_W-1:0] wr_field, code_q;
  logic [RATIO_W-1:0] wr_ratio, pend_ratio, cur_ratio;
  logic               wr_valid, pend_valid, err_q;

  clkdiv_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIELD_W(FIELD_W),
    .FIELD_SHIFT(FIELD_SHIFT), .RATIO_W(RATIO_W), .RST_CODE(RST_CODE)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .wr_field(wr_field), .wr_valid(wr_valid),
    .cur_ratio(cur_ratio), .code_q(code_q), .err_q(err_q),
    .bus_rdata(bus_rdata)
  );

  // Decoder judging the incoming write
  clkdiv_decode #(
    .MODE(MODE), .FIELD_W(FIELD_W), .RATIO_W(RATIO_W),
    .MIN_RATIO(MIN_RATIO), .MAX_RATIO(MAX_RATIO), .DIV_TABLE(DIV_TABLE)
  ) u_dec_wr (
    .code(wr_field), .ratio(wr_ratio), .valid(wr_valid)
  );

  // Decoder producing the ratio of the stored code
  clkdiv_decode #(
    .MODE(MODE), .FIELD_W(FIELD_W), .RATIO_W(RATIO_W),
    .MIN_RATIO(MIN_RATIO), .MAX_RATIO(MAX_RATIO), .DIV_TABLE(DIV_TABLE)
  ) u_dec_cur (
    .code(code_q), .ratio(pend_ratio), .valid(pend_valid)
  );

  clkdiv_gen #(.RATIO_W(RATIO_W)) u_gen (
    .clk(clk), .rst(rst), .pend_ratio(pend_ratio), .cur_ratio(cur_ratio),
    .clk_en(clk_en), .div_phase(div_phase)
  );

  assign cfg_err = err_q;

  assert_stored_code_legal_R7: assert property (@(posedge clk) disable iff (rst)
    pend_valid);

  assert_accepted_write_legal_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (bus_addr == ADDR_W'(clkdiv_pkg::REG_CTRL)) && wr_valid)
      |-> (wr_ratio != '0));
endmodule

// File: tb/test_clkdiv_prog.sv
module test_clkdiv_prog;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_w [4];
  logic [3:0]  en_w, ph_w, err_w;

  int checks = 0;
  int errors = 0;

  // Table used by the table-mode instance: entry i at bits [i*8 +: 8]
  localparam logic [127:0] TBL = 128'h0200_0000_0000_0000_0000_0503_1000_0804;
  int tbl [16] = '{4, 8, 0, 16, 3, 5, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2};

  int code_exp [4];
  int ratio_exp [4];
  int err_exp [4];

  always #5 clk = ~clk;

  clkdiv_prog #(.MAX_RATIO(12), .MODE(clkdiv_pkg::DEC_OFFSET), .RST_CODE(0))
  i_clkdiv_prog (.clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_w[0]), .clk_en(en_w[0]),
    .div_phase(ph_w[0]), .cfg_err(err_w[0]));

  clkdiv_prog #(.MIN_RATIO(2), .MAX_RATIO(12), .MODE(clkdiv_pkg::DEC_DIRECT), .RST_CODE(2))
  i_clkdiv_prog_dir (.clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_w[1]), .clk_en(en_w[1]),
    .div_phase(ph_w[1]), .cfg_err(err_w[1]));

  clkdiv_prog #(.MAX_RATIO(64), .MODE(clkdiv_pkg::DEC_POW2), .RST_CODE(0))
  i_clkdiv_prog_p2 (.clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_w[2]), .clk_en(en_w[2]),
    .div_phase(ph_w[2]), .cfg_err(err_w[2]));

  clkdiv_prog #(.MODE(clkdiv_pkg::DEC_TABLE), .DIV_TABLE(TBL), .RST_CODE(0))
  i_clkdiv_prog_tbl (.clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_w[3]), .clk_en(en_w[3]),
    .div_phase(ph_w[3]), .cfg_err(err_w[3]));

  // Reference decode per instance, from R1..R5
  function automatic void ref_decode(input int k, input int code,
                                     output bit ok, output int r);
    case (k)
      0: begin r = code + 1; ok = (r >= 1) && (r <= 12); end
      1: begin r = code;     ok = (r >= 2) && (r <= 12); end
      2: begin r = (code < 8) ? (1 << code) : 0; ok = (r >= 1) && (r <= 64); end
      default: begin r = tbl[code]; ok = (r != 0); end
    endcase
  endfunction

  task automatic chk(input string tag, input int k, input string what,
                     input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s inst%0d %s: actual %0d expected %0d", tag, k, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int k, input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = rdata_w[k];
  endtask

  task automatic apply_expect(input int code);
    for (int k = 0; k < 4; k++) begin
      bit ok; int r;
      ref_decode(k, code, ok, r);
      if (ok) begin code_exp[k] = code; ratio_exp[k] = r; end
      else err_exp[k] = 1;
    end
  endtask

  // control write with junk outside the field (R6)
  task automatic apply(input int code);
    wr(2'd0, 32'hA5A5_F0A5 | (32'(code) << 8));
    apply_expect(code);
  endtask

  // one period starting at an enable cycle
  task automatic measure(input int k, output int period, output int high);
    while (en_w[k] !== 1'b1) @(negedge clk);
    period = 0; high = 0;
    do begin
      if (ph_w[k]) high++;
      period++;
      @(negedge clk);
    end while (en_w[k] !== 1'b1);
  endtask

  task automatic check_inst(input int k, input string tag);
    int p, h, eh;
    logic [31:0] d;
    for (int i = 0; i < 3; i++) measure(k, p, h);
    eh = (ratio_exp[k] == 1) ? 1 : ratio_exp[k] / 2;
    chk(tag, k, "period (R9)", p, ratio_exp[k]);
    chk(tag, k, "high cycles (R10)", h, eh);
    rd(k, 2'd0, d);
    chk(tag, k, "control readback (R6)", d, 64'(code_exp[k]) << 8);
    rd(k, 2'd1, d);
    chk(tag, k, "status word (R11)", d, (64'(err_exp[k]) << 31) | 64'(ratio_exp[k]));
    chk(tag, k, "cfg_err (R7)", err_w[k], err_exp[k]);
  endtask

  task automatic check_all(input string tag);
    for (int k = 0; k < 4; k++) check_inst(k, tag);
  endtask

  task automatic t_reset;
    code_exp = '{0, 2, 0, 0};
    err_exp  = '{0, 0, 0, 0};
    for (int k = 0; k < 4; k++) begin
      bit ok; int r;
      ref_decode(k, code_exp[k], ok, r);
      ratio_exp[k] = r;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_all("R12 reset");
  endtask

  task automatic t_clear;
    wr(2'd1, 32'h8000_0000);
    err_exp = '{0, 0, 0, 0};
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R7 clear", k, "cfg_err after clear", err_w[k], 0);
    end
  endtask

  task automatic t_offset;
    apply(3);  check_all("R1 code3");
    apply(11); check_all("R1 code11");
    apply(13); check_all("R5 above max");
    t_clear();
  endtask

  task automatic t_direct;
    apply(0); check_all("R2 code0");
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R9 ratio1", 0, "enable held", en_w[0], 1);
      chk("R9 ratio1", 0, "phase held", ph_w[0], 1);
    end
    apply(1); check_all("R5 below min");
    t_clear();
  endtask

  task automatic t_pow2;
    apply(6); check_all("R3 code6");
    apply(7); check_all("R3 code7 over max");
    t_clear();
  endtask

  task automatic t_table;
    apply(2); check_all("R4 zero entry");
    apply(3); check_all("R4 entry16");
    apply(4); check_all("R10 odd ratio");
    t_clear();
  endtask

  task automatic t_field;
    wr(2'd0, 32'hFFFF_F5FF);
    apply_expect(5);
    check_all("R6 junk bits");
  endtask

  // change in mid-period must not cut the running period
  task automatic t_boundary;
    int p, h;
    apply(9); check_inst(0, "R8 setup");
    while (en_w[0] !== 1'b1) @(negedge clk);
    wr(2'd0, 32'h0000_0100);
    apply_expect(1);
    p = 2;
    while (en_w[0] !== 1'b1) begin p++; @(negedge clk); end
    chk("R8 period during change", 0, "period", p, 10);
    measure(0, p, h);
    chk("R8 first new period", 0, "period", p, 2);
    check_all("R8 after change");
    t_clear();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_offset();
    t_direct();
    t_pow2();
    t_table();
    t_field();
    t_boundary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule